// File: doc/BRIEF.md
# Edge-Triggered Control Line Interrupt Unit

This block serves one side of a parallel port adapter. It watches two peripheral control inputs, a primary line and a secondary line. For each line it detects an active edge whose direction software chooses. Each detected edge sets a sticky status flag. The two flags are the values software reads back in bits 7 (primary) and 6 (secondary) of the port's control register. The surrounding register logic supplies the relevant control register bits on two small configuration ports.

A flag is set by its edge whether or not its interrupt is enabled. The enable bit only gates the shared active-low interrupt request. That request is driven in open-drain style: the block either pulls the line low or releases it. A processor read of the port data register clears both flags. Both lines pass through a two-flop synchronizer before edge detection, so every event reaches the flags a fixed number of bus clocks after the pin changes.

When the secondary line is configured as an output, edges on it are ignored. Its interrupt enable then has no effect.

Top module: `ctl_line_irq`

## Requirements
- R1: After reset, both flags read 0, `irq_n` is 1 and `irq_pull` is 0.
- R2: `c1_cfg[1]` selects the active edge of the primary line: 0 means falling, 1 means rising. An active edge makes `flag_c1` read 1 on the third clock after the pin changes. The opposite edge leaves the flag at 0.
- R3: `flag_c1` is set by an active primary edge whatever the value of `c1_cfg[0]`.
- R4: With `c1_cfg[0]` = 1 and `flag_c1` = 1, `irq_n` is 0. With `c1_cfg[0]` = 0, the primary flag has no effect on `irq_n`.
- R5: When `c2_cfg[2]` = 0 (secondary line is an input), `c2_cfg[1]` selects its active edge (0 falling, 1 rising). `flag_c2` is set by that edge whatever the value of `c2_cfg[0]`. `irq_n` goes low while `flag_c2` = 1 and `c2_cfg[0]` = 1.
- R6: Once set, a flag stays set until `data_rd` is high on a clock edge. A single-cycle `data_rd` clears both flags, and the cleared value is visible after that edge.
- R7: If an active edge is being registered in the same cycle that `data_rd` is high, the flag ends up set.
- R8: When `c2_cfg[2]` = 1 (secondary line is an output), edges on `c2_in` never set `flag_c2`, and `c2_cfg[0]` has no effect on `irq_n`.
- R9: `irq_pull` is 1 exactly when `irq_n` is 0. `irq_n` is low when either enabled flag condition holds.
- R10: Changing an edge select bit while its line is steady sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c1_cfg | input | 2 | Primary line config: [1] edge select, [0] interrupt enable |
| c2_cfg | input | 3 | Secondary line config: [2] output mode, [1] edge select, [0] interrupt enable |
| c1_in | input | 1 | Primary control line (asynchronous) |
| c2_in | input | 1 | Secondary control line (asynchronous) |
| data_rd | input | 1 | One-cycle strobe for a processor read of the port data register |
| flag_c1 | output | 1 | Primary status flag (control register bit 7) |
| flag_c2 | output | 1 | Secondary status flag (control register bit 6) |
| irq_n | output | 1 | Active-low interrupt request level |
| irq_pull | output | 1 | Open-drain pull-down enable for the request line |

## Verification
A wrong synchronizer depth or a misplaced edge register moves the flag's rise earlier or later than the third clock. The bench samples both the second and the third clock, so such a fault shows immediately. A polarity or gating fault shows as a flag or request that is present or missing on the first event of a sweep point. A broken clear or a broken set priority shows one clock after the read strobe. The sweep covers every line, edge select and enable combination, so any of these faults appears within a few tens of cycles.

// File: rtl/ctl_line_irq.sv
module ctl_line_irq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] c1_cfg,
  input  logic [2:0] c2_cfg,
  input  logic       c1_in,
  input  logic       c2_in,
  input  logic       data_rd,
  output logic       flag_c1,
  output logic       flag_c2,
  output logic       irq_n,
  output logic       irq_pull
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] pin, rising_sel, armed, irq_en;
  logic [NLINES-1:0] prev_q, edge_hit, flag_q;
  logic [SYNC_STAGES-1:0] sync_q [NLINES];

  assign pin        = {c2_in, c1_in};
  assign rising_sel = {c2_cfg[1], c1_cfg[1]};
  assign armed      = {~c2_cfg[2], 1'b1};
  assign irq_en     = {c2_cfg[0] & ~c2_cfg[2], c1_cfg[0]};

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic synced;
    assign synced = sync_q[i][SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q[i] <= '0;
        prev_q[i] <= 1'b0;
      end else begin
        sync_q[i] <= {sync_q[i][SYNC_STAGES-2:0], pin[i]};
        prev_q[i] <= synced;
      end
    end

    assign edge_hit[i] = armed[i] &
      (rising_sel[i] ? (synced & ~prev_q[i]) : (~synced & prev_q[i]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flag_q[i] <= 1'b0;
      else if (edge_hit[i]) flag_q[i] <= 1'b1;
      else if (data_rd)     flag_q[i] <= 1'b0;
    end

    p_flag_needs_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[i]) |-> $past(edge_hit[i]));
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[i] && !data_rd |=> flag_q[i]);
    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      data_rd && !edge_hit[i] |=> !flag_q[i]);
    p_edge_beats_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit[i] && data_rd |=> flag_q[i]);
  end

  assign flag_c1  = flag_q[0];
  assign flag_c2  = flag_q[1];
  assign irq_pull = |(flag_q & irq_en);
  assign irq_n    = ~irq_pull;

  p_out_mode_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[1]) |-> !$past(c2_cfg[2]));
  p_irq_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !c1_cfg[0] && (!c2_cfg[0] || c2_cfg[2]) |-> irq_n);
  p_irq_c1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_c1 && c1_cfg[0] |-> !irq_n);
  p_pull_matches_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pull != irq_n);
endmodule

// File: tb/tb_ctl_line_irq.sv
module tb_ctl_line_irq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] c1_cfg = '0;
  logic [2:0] c2_cfg = '0;
  logic c1_in = 1'b0, c2_in = 1'b0, data_rd = 1'b0;
  logic flag_c1, flag_c2, irq_n, irq_pull;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ctl_line_irq dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic set_pin(input int ln, input bit v);
    if (ln == 0) c1_in = v; else c2_in = v;
  endtask

  function automatic bit flag_of(input int ln);
    return (ln == 0) ? flag_c1 : flag_c2;
  endfunction

  task automatic do_read();
    data_rd = 1'b1; tick(1); data_rd = 1'b0;
  endtask

  task automatic sweep_point(input int ln, input bit pol, input bit en);
    bit f;
    if (ln == 0) begin c1_cfg = {pol, en}; c2_cfg = 3'b000; end
    else begin c1_cfg = 2'b00; c2_cfg = {1'b0, pol, en}; end
    set_pin(ln, !pol); tick(5);
    do_read();
    f = flag_of(ln);
    check(f == 0, "R2 idle/opposite edge", f, 0);
    set_pin(ln, pol); tick(2);
    f = flag_of(ln);
    check(f == 0, "R2 not before third clock", f, 0);
    tick(1);
    f = flag_of(ln);
    check(f == 1, ln == 0 ? "R2 R3 flag on active edge" : "R5 flag on active edge", f, 1);
    check(irq_n == !en, ln == 0 ? "R4 irq gating" : "R5 irq gating", irq_n, !en);
    check(irq_pull == en, "R9 pull", irq_pull, en);
    set_pin(ln, !pol); tick(4);
    f = flag_of(ln);
    check(f == 1, "R6 sticky", f, 1);
    do_read();
    f = flag_of(ln);
    check(f == 0, "R6 clear on read", f, 0);
    check(irq_n == 1, "R6 irq released", irq_n, 1);
  endtask

  initial begin
    tick(3);
    check(flag_c1 == 0 && flag_c2 == 0, "R1 flags", {flag_c1, flag_c2}, 0);
    check(irq_n == 1 && irq_pull == 0, "R1 irq", {irq_n, irq_pull}, 2);
    rst_n = 1'b1; tick(2);

    for (int ln = 0; ln < 2; ln++)
      for (int p = 0; p < 2; p++)
        for (int e = 0; e < 2; e++)
          sweep_point(ln, p[0], e[0]);

    // R7: edge registered in the cycle of the read
    c1_cfg = 2'b10; c2_cfg = 3'b000; c1_in = 0; tick(5); do_read();
    c1_in = 1; tick(2); data_rd = 1; tick(1); data_rd = 0;
    check(flag_c1 == 1, "R7 set wins over clear", flag_c1, 1);
    do_read();

    // R8: output mode ignores secondary edges and enable
    c1_cfg = 2'b00; c2_cfg = 3'b111; c2_in = 0; tick(5); do_read();
    c2_in = 1; tick(4); c2_in = 0; tick(4);
    check(flag_c2 == 0, "R8 no flag in output mode", flag_c2, 0);
    check(irq_n == 1, "R8 irq released", irq_n, 1);

    // R8: flag set in input mode, then output mode drops its irq
    c2_cfg = 3'b011; c2_in = 1; tick(4);
    check(irq_n == 0, "R5 irq in input mode", irq_n, 0);
    c2_cfg = 3'b111; tick(1);
    check(irq_n == 1, "R8 enable ignored in output mode", irq_n, 1);
    do_read();

    // R10: polarity flip on steady lines
    c2_cfg = 3'b000; c1_cfg = 2'b01; c1_in = 1; c2_in = 1; tick(5); do_read();
    c1_cfg = 2'b11; c2_cfg = 3'b010; tick(3);
    c1_cfg = 2'b01; c2_cfg = 3'b000; tick(3);
    check(flag_c1 == 0 && flag_c2 == 0, "R10 no flag on select change", {flag_c1, flag_c2}, 0);

    // R9: both enabled flags set together
    c1_cfg = 2'b01; c2_cfg = 3'b001; c1_in = 0; c2_in = 0; tick(4);
    check(flag_c1 && flag_c2 && !irq_n && irq_pull, "R9 both lines",
          {flag_c1, flag_c2, irq_n, irq_pull}, 4'b1101);
    do_read();
    check(!flag_c1 && !flag_c2, "R6 read clears both", {flag_c1, flag_c2}, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin tick(20000); check(0, "watchdog", 0, 1); end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule